// File: doc/BRIEF.md
# Register Scoreboard With Dependent Wakeup

This block holds one readiness bit per physical register and a small window of waiting instructions. Each window slot records a sequence number, two source register tags with a ready bit each, and one destination tag. When an instruction is written into a slot, it reads the readiness of its sources. A source that is already available is marked ready at once and does not wait. The instruction also claims its destination register, so that register reads as pending.

When a producer finishes, its destination tag is broadcast on the completion port. The scoreboard bit for that tag is set, and every waiting source that carries the tag in a live slot is marked ready. A slot raises its issue-ready flag once both of its sources are ready. A flush port removes live slots that are younger than a given sequence number, so those slots no longer wake or issue.

Tags at or above the physical register count are outside the scoreboard. They never wait, and they are never written. Slot allocation, operand values, issue selection and execution all live outside this block.

Top module: `reg_wakeup_sb`

## Requirements
- R1: After reset, every bit of `reg_ready` is 0, every bit of `slot_valid` is 0, and every bit of `issue_ready` is 0.
- R2: An insertion (`ins_valid`=1) whose destination tag is below NUM_PREGS clears that register's `reg_ready` bit from the next cycle on. If a completion of the same tag arrives in the same cycle, the clear wins.
- R3: A completion (`done_valid`=1) of a tag below NUM_PREGS sets that register's `reg_ready` bit. In the same cycle it marks ready every source holding that tag in a valid slot.
- R4: A tag at or above NUM_PREGS is untracked. As a source it counts as ready at insertion. As a destination it changes no `reg_ready` bit. A completion of such a tag changes no `reg_ready` bit and wakes no source.
- R5: At insertion, a tracked source whose `reg_ready` bit is already 1 is marked ready immediately. A tracked source whose bit is 0 waits for a completion.
- R6: When a completion and an insertion happen in the same cycle, a source of the new instruction that matches the completed tag is ready.
- R7: A flush (`flush_valid`=1) clears `slot_valid` for every valid slot whose sequence number is greater than `flush_seq`, using an unsigned compare. A slot whose number is equal or smaller stays valid. An insertion in the same cycle is written regardless of the flush.
- R8: `issue_ready[i]` is 1 exactly when slot i is valid and both of its sources are ready. It reflects the cycle's insert, completion and flush from the following cycle on.
- R9: An insertion into slot `ins_slot` replaces whatever that slot held before, valid or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Write an instruction into a slot this cycle |
| ins_slot | input | SLOT_W | Target slot index |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_src_a | input | TAG_W | First source tag |
| ins_src_b | input | TAG_W | Second source tag |
| ins_dst | input | TAG_W | Destination tag |
| done_valid | input | 1 | A producer completes this cycle |
| done_tag | input | TAG_W | Destination tag of the completing producer |
| flush_valid | input | 1 | Flush younger slots this cycle |
| flush_seq | input | SEQ_W | Sequence number of the flush point |
| slot_valid | output | WIN | Slot holds a live instruction |
| issue_ready | output | WIN | Slot is valid with both sources ready |
| reg_ready | output | NUM_PREGS | Scoreboard bit per physical register |

## Verification
The stimulus table drives waiting chains in which one completion releases a consumer and that consumer's own result releases the next. This separates a correct wakeup from one that keys on the wrong source or the wrong slot. The same table covers several special cases: a source already produced before insertion, insertion in the same cycle as completion, and a flush at a point equal to a live slot's number. These separate the scoreboard lookup, the forwarding path and the boundary of the sequence compare. Completions and sources above the register count, and a producer re-claimed while its old value completes, show whether untracked tags and the clear-over-set priority are handled. After every cycle, a per-register reference model is checked against the whole scoreboard.

// File: rtl/reg_wakeup_sb.sv
module reg_wakeup_sb #(
  parameter int NUM_PREGS = 32,
  parameter int TAG_W     = 6,
  parameter int WIN       = 4,
  parameter int SEQ_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [$clog2(WIN)-1:0] ins_slot,
  input  logic [SEQ_W-1:0]     ins_seq,
  input  logic [TAG_W-1:0]     ins_src_a,
  input  logic [TAG_W-1:0]     ins_src_b,
  input  logic [TAG_W-1:0]     ins_dst,
  input  logic                 done_valid,
  input  logic [TAG_W-1:0]     done_tag,
  input  logic                 flush_valid,
  input  logic [SEQ_W-1:0]     flush_seq,
  output logic [WIN-1:0]       slot_valid,
  output logic [WIN-1:0]       issue_ready,
  output logic [NUM_PREGS-1:0] reg_ready
);
  localparam int SLOT_W = $clog2(WIN);
  localparam int IDX_W  = $clog2(NUM_PREGS);
  localparam logic [TAG_W:0] NPR = NUM_PREGS[TAG_W:0];

  logic [NUM_PREGS-1:0] sb;
  logic [SEQ_W-1:0]     seq_q [WIN];
  logic [TAG_W-1:0]     ta_q  [WIN];
  logic [TAG_W-1:0]     tb_q  [WIN];
  logic [WIN-1:0]       vld_q, ra_q, rb_q;

  logic done_trk, dst_trk;
  assign done_trk = done_valid && ({1'b0, done_tag} < NPR);
  assign dst_trk  = ins_valid && ({1'b0, ins_dst} < NPR);

  function automatic logic src_ok(input logic [TAG_W-1:0] t);
    if ({1'b0, t} >= NPR) return 1'b1;
    return sb[t[IDX_W-1:0]] || (done_trk && done_tag == t);
  endfunction

  logic src_a_ok, src_b_ok;
  assign src_a_ok = src_ok(ins_src_a);
  assign src_b_ok = src_ok(ins_src_b);

  always_ff @(posedge clk) begin
    if (!rst_n) sb <= '0;
    else begin
      if (done_trk) sb[done_tag[IDX_W-1:0]] <= 1'b1;
      if (dst_trk)  sb[ins_dst[IDX_W-1:0]]  <= 1'b0;
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_slot
    logic put;
    assign put = ins_valid && (ins_slot == SLOT_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        ra_q[i]  <= 1'b0;
        rb_q[i]  <= 1'b0;
        seq_q[i] <= '0;
        ta_q[i]  <= '0;
        tb_q[i]  <= '0;
      end else if (put) begin
        vld_q[i] <= 1'b1;
        seq_q[i] <= ins_seq;
        ta_q[i]  <= ins_src_a;
        tb_q[i]  <= ins_src_b;
        ra_q[i]  <= src_a_ok;
        rb_q[i]  <= src_b_ok;
      end else begin
        if (flush_valid && seq_q[i] > flush_seq) vld_q[i] <= 1'b0;
        if (done_trk && ta_q[i] == done_tag) ra_q[i] <= 1'b1;
        if (done_trk && tb_q[i] == done_tag) rb_q[i] <= 1'b1;
      end
    end

    // R8: ready stays set while the slot is left untouched
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_ready[i] && !put && !flush_valid) |=> issue_ready[i]);
  end

  assign slot_valid  = vld_q;
  assign issue_ready = vld_q & ra_q & rb_q;
  assign reg_ready   = sb;

  a_r2_ins_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dst_trk |=> !reg_ready[$past(ins_dst[IDX_W-1:0])]);

  a_r3_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_trk && !(ins_valid && ins_dst == done_tag))
      |=> reg_ready[$past(done_tag[IDX_W-1:0])]);

  a_r4_untracked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_trk && !dst_trk) |=> $stable(reg_ready));

  a_r7_flush_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !ins_valid)
      |=> ($countones(slot_valid) <= $past($countones(slot_valid))));
endmodule

// File: tb/reg_wakeup_sb_tb_top.sv
module reg_wakeup_sb_tb_top;
  localparam int NP = 32;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic ins_valid, done_valid, flush_valid;
  logic [1:0] ins_slot;
  logic [7:0] ins_seq, flush_seq;
  logic [5:0] ins_src_a, ins_src_b, ins_dst, done_tag;
  logic [3:0] slot_valid, issue_ready;
  logic [NP-1:0] reg_ready;

  reg_wakeup_sb dut_i (
    .clk, .rst_n, .ins_valid, .ins_slot, .ins_seq, .ins_src_a, .ins_src_b,
    .ins_dst, .done_valid, .done_tag, .flush_valid, .flush_seq,
    .slot_valid, .issue_ready, .reg_ready
  );

  int checks = 0;
  int bad = 0;
  logic [NP-1:0] model_sb;

  function automatic logic [48:0] mk(int iv, int sl, int sq, int a, int b, int d,
                                     int cv, int ct, int fv, int fs, int ex);
    return {iv[0], sl[1:0], sq[7:0], a[5:0], b[5:0], d[5:0],
            cv[0], ct[5:0], fv[0], fs[7:0], ex[3:0]};
  endfunction

  // fields: ins valid,slot,seq,srcA,srcB,dst | done valid,tag | flush valid,seq | expected issue_ready
  localparam logic [48:0] VEC [NV] = '{
    mk(1,0,10, 1, 2, 3, 0, 0, 0, 0, 4'b0000), // R5 both sources pending
    mk(0,0, 0, 0, 0, 0, 1, 1, 0, 0, 4'b0000), // R3 one source wakes
    mk(1,1,11, 3,40, 4, 1, 2, 0, 0, 4'b0001), // R3 R4 slot0 ready, untracked src
    mk(0,0, 0, 0, 0, 0, 1, 3, 0, 0, 4'b0011), // R3 chain wakeup
    mk(1,2,12, 4, 4, 5, 1, 4, 0, 0, 4'b0111), // R6 same-cycle forwarding
    mk(1,3,13, 1, 5, 6, 0, 0, 0, 0, 4'b0111), // R5 R2 r1 set, r5 cleared
    mk(0,0, 0, 0, 0, 0, 0, 0, 1,11, 4'b0011), // R7 flush, equal seq kept
    mk(0,0, 0, 0, 0, 0, 1, 5, 0, 0, 4'b0011), // R7 flushed slot not woken
    mk(1,3,14, 5, 6, 7, 0, 0, 0, 0, 4'b0011), // R5 one ready, one pending
    mk(0,0, 0, 0, 0, 0, 1,38, 0, 0, 4'b0011), // R4 untracked completion
    mk(1,2,15, 7,33, 8, 1, 6, 0, 0, 4'b1011), // R3 R9 overwrite slot2
    mk(1,0,16, 8, 8, 9, 1, 7, 0, 0, 4'b1110), // R9 overwrite valid slot0
    mk(1,1,17, 0, 0, 8, 1, 8, 0, 0, 4'b1101), // R2 clear beats set
    mk(1,1,21,40,50,60, 0, 0, 1,20, 4'b1111)  // R7 R4 insert survives flush
  };

  task automatic idle();
    ins_valid = 0; ins_slot = 0; ins_seq = 0; ins_src_a = 0; ins_src_b = 0;
    ins_dst = 0; done_valid = 0; done_tag = 0; flush_valid = 0; flush_seq = 0;
  endtask

  task automatic check_reset(string tag);
    checks++;
    if (slot_valid !== 0 || issue_ready !== 0 || reg_ready !== 0) begin
      bad++;
      $display("FAIL %s reset: valid=%b ready=%b regs=%h expected 0", tag,
               slot_valid, issue_ready, reg_ready);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1;
    model_sb = '0;
    for (int v = 0; v < NV; v++) begin
      logic [48:0] w;
      @(negedge clk);
      w = VEC[v];
      {ins_valid, ins_slot, ins_seq, ins_src_a, ins_src_b, ins_dst,
       done_valid, done_tag, flush_valid, flush_seq} = w[48:4];
      @(posedge clk);
      if (done_valid && done_tag < NP) model_sb[done_tag[4:0]] = 1'b1;
      if (ins_valid && ins_dst < NP) model_sb[ins_dst[4:0]] = 1'b0;
      @(negedge clk);
      idle();
      checks++;
      if (issue_ready !== w[3:0]) begin
        bad++;
        $display("FAIL R8 vec %0d: issue_ready=%b expected %b", v, issue_ready, w[3:0]);
      end
      checks++;
      if (reg_ready !== model_sb) begin
        bad++;
        $display("FAIL R2 R3 R4 vec %0d: reg_ready=%h expected %h", v, reg_ready, model_sb);
      end
    end
    // R7: slots 0..3 live with seq 16,21,15,14; flush at 15 drops 16 and 21
    @(negedge clk);
    flush_valid = 1; flush_seq = 15;
    @(negedge clk);
    idle();
    checks++;
    if (slot_valid !== 4'b1100) begin
      bad++;
      $display("FAIL R7 flush boundary: slot_valid=%b expected 1100", slot_valid);
    end
    // R1: reset in mid-run clears everything
    rst_n = 0;
    @(negedge clk);
    check_reset("R1 mid-run");
    rst_n = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule